// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This bridge sits between a processor-side request port and a memory-side request port. It maps two 32 MB alias windows onto two target regions. Inside a window, each 32-bit aligned alias word stands for one bit of the target region. A read from an alias word returns that bit as 0 or 1. A write to an alias word sets or clears that single bit through a locked read-modify-write of the target. Every other address is forwarded downstream as it is.

Both sides use valid/ready handshakes. The processor side has a request channel and a response channel, and every request gets exactly one response beat; for a write that beat carries zero data. On the memory side, a write is complete once its request is accepted. A read is complete when one beat returns on the memory response channel. The data bus is 32 bits wide and little-endian: a byte or halfword sits in the lanes picked by the low address bits. Sizes are encoded 0 = byte, 1 = halfword, 2 = word.

The control is a single state machine with seven states:
- `ST_IDLE` accepts a request. It takes *idle→alias-read* on an alias hit and *idle→forward* otherwise.
- `ST_FWD_REQ` issues the forwarded transaction. It takes *forward→respond* for a write and *forward→await* for a read.
- `ST_FWD_WAIT` takes *await→respond* when the read data arrives.
- `ST_BB_RD` issues the target read and takes *alias-read→alias-wait*.
- `ST_BB_WAIT` takes *alias-wait→write-back* for an alias write and *alias-wait→respond* for an alias read.
- `ST_BB_WB` issues the write-back and takes *write-back→respond*.
- `ST_RESP` presents the response and takes *respond→idle* when it is accepted.

Top module: `bitband_bridge`

## Requirements
- R1: After reset the bridge is idle: `up_req_ready` is 1, and `up_rsp_valid` and `dn_req_valid` are both 0.
- R2: Address bits 31:25 equal to 0x11 select window A, which targets base 0x20000000. Bits 31:25 equal to 0x21 select window B, which targets base 0x40000000. Any other address is not an alias access, including the words just below and just above a window.
- R3: The target address is the window's target base ORed with alias address bits 24:5. For a halfword it is then forced to an even address, and for a word it is forced to a multiple of four.
- R4: The selected bit depends on the size. For a byte it is alias bits 4:2. For a halfword it is alias bits 5:2. For a word it is alias bits 6:2. The bit is counted inside the little-endian value of the addressed target, so on the bus it sits at bit 8·(target[1:0]) + index for a byte and 16·target[1] + index for a halfword.
- R5: An alias read issues one downstream read of the same size. It responds with the selected bit in bit 0 and zeros in bits 31:1.
- R6: An alias write reads the target at the request's size. It then writes back, at that size and address, the value with the selected bit set if write-data bit 0 is 1 and cleared otherwise. All other bits of the target keep their values.
- R7: For an alias write, the downstream read and the write-back are issued back to back to the same address. No other downstream request comes between them.
- R8: An alias write responds only after its write-back has been accepted. Any read, alias or forwarded, responds only after its downstream data has returned.
- R9: A non-alias request produces exactly one downstream transaction with the original address, size, direction and write data. A forwarded read responds with the downstream data unchanged.
- R10: Only one request is outstanding. `up_req_ready` stays 0 from the accepted request until its response has been accepted.
- R11: While `dn_req_valid` or `up_rsp_valid` is high and not accepted, it stays high and its payload does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_req_valid | input | 1 | Processor request valid |
| up_req_ready | output | 1 | Bridge can accept a request |
| up_req_addr | input | 32 | Request byte address |
| up_req_write | input | 1 | 1 = write, 0 = read |
| up_req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| up_req_wdata | input | 32 | Write data, lane-aligned |
| up_rsp_valid | output | 1 | Response valid |
| up_rsp_ready | input | 1 | Processor accepts response |
| up_rsp_rdata | output | 32 | Response data |
| dn_req_valid | output | 1 | Downstream request valid |
| dn_req_ready | input | 1 | Downstream accepts request |
| dn_req_addr | output | 32 | Downstream byte address |
| dn_req_write | output | 1 | Downstream direction |
| dn_req_size | output | 2 | Downstream size |
| dn_req_wdata | output | 32 | Downstream write data |
| dn_rsp_valid | input | 1 | Downstream read data valid |
| dn_rsp_ready | output | 1 | Bridge accepts read data |
| dn_rsp_rdata | input | 32 | Downstream read data |

## Verification
A wrong state shows at the ports within one handshake. A bridge stuck in a read path asserts `dn_rsp_ready` without having issued a read. A write-back state entered early puts a downstream write ahead of the target read. Either one breaks the expected downstream sequence the bench checks at each accepted request. A wrong latched lane bit or target address is invisible until the response or the write-back. It then shows as a wrong response bit, or as a changed neighbouring bit in the target memory, which the bench compares right after the request completes.

// File: rtl/bb_pkg.sv
package bb_pkg;

    localparam int BB_ADDR_W = 32;
    localparam int BB_DATA_W = 32;
    localparam int BB_LANE_W = $clog2(BB_DATA_W);

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_FWD_REQ  = 3'd1,
        ST_FWD_WAIT = 3'd2,
        ST_BB_RD    = 3'd3,
        ST_BB_WAIT  = 3'd4,
        ST_BB_WB    = 3'd5,
        ST_RESP     = 3'd6
    } bb_state_e;

    typedef struct packed {
        logic                 hit;
        logic [BB_ADDR_W-1:0] taddr;
        logic [BB_LANE_W-1:0] lane_bit;
    } bb_xlate_t;

endpackage

// File: rtl/bb_alias_decode.sv
module bb_alias_decode
    import bb_pkg::*;
#(
    parameter int NUM_WIN   = 2,
    parameter int SPAN_LOG2 = 25,
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic [BB_ADDR_W-1:2] word_addr,
    input  logic [1:0]           size,
    output bb_xlate_t            xl
);

    localparam int HI_W  = BB_ADDR_W - SPAN_LOG2;
    localparam int OFF_W = SPAN_LOG2 - 5;

    logic [NUM_WIN-1:0]   hit_vec;
    logic [BB_ADDR_W-1:0] raw_vec [NUM_WIN];
    logic [BB_ADDR_W-1:0] raw;

    // one comparator and one base merge per window
    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        assign hit_vec[w] = (word_addr[BB_ADDR_W-1:SPAN_LOG2] ==
                             ALIAS_BASES[w*BB_ADDR_W+SPAN_LOG2 +: HI_W]);
        assign raw_vec[w] = TARGET_BASES[w*BB_ADDR_W +: BB_ADDR_W] |
                            {{(BB_ADDR_W-OFF_W){1'b0}}, word_addr[SPAN_LOG2-1:5]};
    end

    // lowest-numbered window wins if windows were ever configured to overlap
    always_comb begin
        raw = '0;
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                raw = raw_vec[i];
            end
        end
    end

    // alignment per size and bus bit position of the selected bit
    always_comb begin
        xl.hit = |hit_vec;
        unique case (size)
            2'b00: begin
                xl.taddr    = raw;
                xl.lane_bit = {raw[1:0], word_addr[4:2]};
            end
            2'b01: begin
                xl.taddr    = {raw[BB_ADDR_W-1:1], 1'b0};
                xl.lane_bit = {raw[1], word_addr[5:2]};
            end
            default: begin
                xl.taddr    = {raw[BB_ADDR_W-1:2], 2'b00};
                xl.lane_bit = word_addr[6:2];
            end
        endcase
    end

endmodule

// File: rtl/bb_bit_merge.sv
module bb_bit_merge
    import bb_pkg::*;
(
    input  logic [BB_DATA_W-1:0] rdata,
    input  logic [BB_LANE_W-1:0] lane_bit,
    input  logic                 set_val,
    output logic                 bit_out,
    output logic [BB_DATA_W-1:0] merged
);

    logic [BB_DATA_W-1:0] mask;

    always_comb begin
        mask    = {{(BB_DATA_W-1){1'b0}}, 1'b1} << lane_bit;
        bit_out = |(rdata & mask);
        merged  = set_val ? (rdata | mask) : (rdata & ~mask);
    end

endmodule

// File: rtl/bitband_bridge.sv
module bitband_bridge
    import bb_pkg::*;
#(
    parameter int NUM_WIN   = 2,
    parameter int SPAN_LOG2 = 25,
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] ALIAS_BASES  = {32'h4200_0000, 32'h2200_0000},
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] TARGET_BASES = {32'h4000_0000, 32'h2000_0000}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 up_req_valid,
    output logic                 up_req_ready,
    input  logic [BB_ADDR_W-1:0] up_req_addr,
    input  logic                 up_req_write,
    input  logic [1:0]           up_req_size,
    input  logic [BB_DATA_W-1:0] up_req_wdata,
    output logic                 up_rsp_valid,
    input  logic                 up_rsp_ready,
    output logic [BB_DATA_W-1:0] up_rsp_rdata,
    output logic                 dn_req_valid,
    input  logic                 dn_req_ready,
    output logic [BB_ADDR_W-1:0] dn_req_addr,
    output logic                 dn_req_write,
    output logic [1:0]           dn_req_size,
    output logic [BB_DATA_W-1:0] dn_req_wdata,
    input  logic                 dn_rsp_valid,
    output logic                 dn_rsp_ready,
    input  logic [BB_DATA_W-1:0] dn_rsp_rdata
);

    bb_state_e            state_q, state_nxt;
    bb_xlate_t            in_xl;
    logic [BB_ADDR_W-1:0] req_addr_q;
    logic [BB_ADDR_W-1:0] tgt_addr_q;
    logic [BB_LANE_W-1:0] lane_bit_q;
    logic [1:0]           req_size_q;
    logic                 req_write_q;
    logic [BB_DATA_W-1:0] req_wdata_q;
    logic [BB_DATA_W-1:0] data_q;
    logic                 sel_bit;
    logic [BB_DATA_W-1:0] merged;
    logic                 up_acc;

    bb_alias_decode #(
        .NUM_WIN      (NUM_WIN),
        .SPAN_LOG2    (SPAN_LOG2),
        .ALIAS_BASES  (ALIAS_BASES),
        .TARGET_BASES (TARGET_BASES)
    ) u_decode (
        .word_addr (up_req_addr[BB_ADDR_W-1:2]),
        .size      (up_req_size),
        .xl        (in_xl)
    );

    bb_bit_merge u_merge (
        .rdata    (dn_rsp_rdata),
        .lane_bit (lane_bit_q),
        .set_val  (req_wdata_q[0]),
        .bit_out  (sel_bit),
        .merged   (merged)
    );

    assign up_acc = (state_q == ST_IDLE) && up_req_valid;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (up_req_valid) begin
                    state_nxt = in_xl.hit ? ST_BB_RD : ST_FWD_REQ;
                end
            end
            ST_FWD_REQ: begin
                if (dn_req_ready) begin
                    state_nxt = req_write_q ? ST_RESP : ST_FWD_WAIT;
                end
            end
            ST_FWD_WAIT: begin
                if (dn_rsp_valid) begin
                    state_nxt = ST_RESP;
                end
            end
            ST_BB_RD: begin
                if (dn_req_ready) begin
                    state_nxt = ST_BB_WAIT;
                end
            end
            ST_BB_WAIT: begin
                if (dn_rsp_valid) begin
                    state_nxt = req_write_q ? ST_BB_WB : ST_RESP;
                end
            end
            ST_BB_WB: begin
                if (dn_req_ready) begin
                    state_nxt = ST_RESP;
                end
            end
            ST_RESP: begin
                if (up_rsp_ready) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        up_req_ready = 1'b0;
        up_rsp_valid = 1'b0;
        up_rsp_rdata = '0;
        dn_req_valid = 1'b0;
        dn_req_addr  = '0;
        dn_req_write = 1'b0;
        dn_req_size  = req_size_q;
        dn_req_wdata = '0;
        dn_rsp_ready = 1'b0;
        unique case (state_q)
            ST_IDLE: up_req_ready = 1'b1;
            ST_FWD_REQ: begin
                dn_req_valid = 1'b1;
                dn_req_addr  = req_addr_q;
                dn_req_write = req_write_q;
                dn_req_wdata = req_wdata_q;
            end
            ST_FWD_WAIT: dn_rsp_ready = 1'b1;
            ST_BB_RD: begin
                dn_req_valid = 1'b1;
                dn_req_addr  = tgt_addr_q;
            end
            ST_BB_WAIT: dn_rsp_ready = 1'b1;
            ST_BB_WB: begin
                dn_req_valid = 1'b1;
                dn_req_addr  = tgt_addr_q;
                dn_req_write = 1'b1;
                dn_req_wdata = data_q;
            end
            ST_RESP: begin
                up_rsp_valid = 1'b1;
                up_rsp_rdata = data_q;
            end
            default: ;
        endcase
    end

    // request capture and data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_addr_q  <= '0;
            tgt_addr_q  <= '0;
            lane_bit_q  <= '0;
            req_size_q  <= '0;
            req_write_q <= 1'b0;
            req_wdata_q <= '0;
            data_q      <= '0;
        end else begin
            if (up_acc) begin
                req_addr_q  <= up_req_addr;
                tgt_addr_q  <= in_xl.taddr;
                lane_bit_q  <= in_xl.lane_bit;
                req_size_q  <= up_req_size;
                req_write_q <= up_req_write;
                req_wdata_q <= up_req_wdata;
            end
            unique case (state_q)
                ST_FWD_REQ: begin
                    if (dn_req_ready && req_write_q) begin
                        data_q <= '0;
                    end
                end
                ST_FWD_WAIT: begin
                    if (dn_rsp_valid) begin
                        data_q <= dn_rsp_rdata;
                    end
                end
                ST_BB_WAIT: begin
                    if (dn_rsp_valid) begin
                        data_q <= req_write_q ? merged
                                              : {{(BB_DATA_W-1){1'b0}}, sel_bit};
                    end
                end
                ST_BB_WB: begin
                    if (dn_req_ready) begin
                        data_q <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/bitband_bridge_chk.sv
module bitband_bridge_chk
    import bb_pkg::*;
#(
    parameter int NUM_WIN   = 2,
    parameter int SPAN_LOG2 = 25,
    parameter logic [NUM_WIN*BB_ADDR_W-1:0] ALIAS_BASES = {32'h4200_0000, 32'h2200_0000}
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 up_req_valid,
    input logic                 up_req_ready,
    input logic [BB_ADDR_W-1:0] up_req_addr,
    input logic                 up_req_write,
    input logic                 up_rsp_valid,
    input logic                 up_rsp_ready,
    input logic [BB_DATA_W-1:0] up_rsp_rdata,
    input logic                 dn_req_valid,
    input logic                 dn_req_ready,
    input logic [BB_ADDR_W-1:0] dn_req_addr,
    input logic                 dn_req_write,
    input logic [1:0]           dn_req_size,
    input logic [BB_DATA_W-1:0] dn_req_wdata,
    input logic                 dn_rsp_valid,
    input logic                 dn_rsp_ready
);

    localparam int HI_W = BB_ADDR_W - SPAN_LOG2;

    logic [NUM_WIN-1:0]   hv;
    logic                 hit;
    logic                 cur_rd, cur_wr, cur_fwd, cur_dir;
    logic [BB_ADDR_W-1:0] cur_addr, rd_addr;
    logic [1:0]           dn_cnt;
    logic                 seen_rsp;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_hit
        assign hv[w] = (up_req_addr[BB_ADDR_W-1:SPAN_LOG2] ==
                        ALIAS_BASES[w*BB_ADDR_W+SPAN_LOG2 +: HI_W]);
    end
    assign hit = |hv;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_rd   <= 1'b0;
            cur_wr   <= 1'b0;
            cur_fwd  <= 1'b0;
            cur_dir  <= 1'b0;
            cur_addr <= '0;
            rd_addr  <= '0;
            dn_cnt   <= '0;
            seen_rsp <= 1'b0;
        end else if (up_req_valid && up_req_ready) begin
            cur_rd   <= hit && !up_req_write;
            cur_wr   <= hit && up_req_write;
            cur_fwd  <= !hit;
            cur_dir  <= up_req_write;
            cur_addr <= up_req_addr;
            dn_cnt   <= '0;
            seen_rsp <= 1'b0;
        end else begin
            if (dn_req_valid && dn_req_ready) begin
                dn_cnt <= dn_cnt + 2'd1;
                if (!dn_req_write) begin
                    rd_addr <= dn_req_addr;
                end
            end
            if (dn_rsp_valid && dn_rsp_ready) begin
                seen_rsp <= 1'b1;
            end
        end
    end

    a_r10_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid || dn_req_valid || dn_rsp_ready) |-> !up_req_ready);

    a_r11_dn_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && !dn_req_ready) |=> (dn_req_valid && $stable(dn_req_addr) &&
            $stable(dn_req_write) && $stable(dn_req_size) && $stable(dn_req_wdata)));

    a_r11_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && !up_rsp_ready) |=> (up_rsp_valid && $stable(up_rsp_rdata)));

    a_r5_bit_in_lsb: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && cur_rd) |-> (up_rsp_rdata[BB_DATA_W-1:1] == '0));

    a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && cur_wr) |-> (dn_req_write == seen_rsp));

    a_r7_same_target: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && cur_wr && seen_rsp) |-> (dn_req_addr == rd_addr));

    a_r8_write_done: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && cur_wr) |-> (dn_cnt == 2'd2));

    a_r8_read_done: assert property (@(posedge clk) disable iff (!rst_n)
        (up_rsp_valid && (cur_rd || (cur_fwd && !cur_dir))) |-> seen_rsp);

    a_r9_forward_once: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req_valid && cur_fwd) |-> (dn_cnt == 2'd0 && dn_req_addr == cur_addr &&
                                       dn_req_write == cur_dir));

endmodule

bind bitband_bridge bitband_bridge_chk #(
    .NUM_WIN     (NUM_WIN),
    .SPAN_LOG2   (SPAN_LOG2),
    .ALIAS_BASES (ALIAS_BASES)
) u_chk (
    .clk, .rst_n, .up_req_valid, .up_req_ready, .up_req_addr, .up_req_write,
    .up_rsp_valid, .up_rsp_ready, .up_rsp_rdata, .dn_req_valid, .dn_req_ready,
    .dn_req_addr, .dn_req_write, .dn_req_size, .dn_req_wdata, .dn_rsp_valid,
    .dn_rsp_ready
);

// File: tb/bitband_bridge_tb_top.sv
module bitband_bridge_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_req_valid = 1'b0;
    logic        up_req_ready;
    logic [31:0] up_req_addr = '0;
    logic        up_req_write = 1'b0;
    logic [1:0]  up_req_size = '0;
    logic [31:0] up_req_wdata = '0;
    logic        up_rsp_valid;
    logic        up_rsp_ready = 1'b0;
    logic [31:0] up_rsp_rdata;
    logic        dn_req_valid;
    logic        dn_req_ready = 1'b0;
    logic [31:0] dn_req_addr;
    logic        dn_req_write;
    logic [1:0]  dn_req_size;
    logic [31:0] dn_req_wdata;
    logic        dn_rsp_valid = 1'b0;
    logic        dn_rsp_ready;
    logic [31:0] dn_rsp_rdata = '0;

    always #5 clk = ~clk;

    bitband_bridge dut_i (
        .clk, .rst_n, .up_req_valid, .up_req_ready, .up_req_addr, .up_req_write,
        .up_req_size, .up_req_wdata, .up_rsp_valid, .up_rsp_ready, .up_rsp_rdata,
        .dn_req_valid, .dn_req_ready, .dn_req_addr, .dn_req_write, .dn_req_size,
        .dn_req_wdata, .dn_rsp_valid, .dn_rsp_ready, .dn_rsp_rdata
    );

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit rnd_mode = 1'b0;
    bit busy = 1'b0;
    bit done = 1'b0;
    logic [7:0]  mem [logic [31:0]];
    logic [34:0] exp_q [$];

    bit          hs_req, hs_req_wr, hs_rsp, prev_stall, pend_act;
    logic [31:0] prev_addr, pend_data;
    int          pend_cnt;

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rdb(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 8'h00;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    // memory model: observe at negedge, act just after posedge
    always @(negedge clk) begin
        hs_req = dn_req_valid && dn_req_ready;
        hs_req_wr = dn_req_write;
        hs_rsp = dn_rsp_valid && dn_rsp_ready;
        if (rst_n) begin
            if (hs_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R7 R9 extra downstream request", dn_req_addr, 32'h0);
                end else begin
                    check({dn_req_write, dn_req_size, dn_req_addr} == exp_q[0],
                          "R3 R7 R9 downstream sequence", dn_req_addr, exp_q[0][31:0]);
                    void'(exp_q.pop_front());
                end
                if (dn_req_write) begin
                    for (int i = 0; i < (1 << dn_req_size); i++) begin
                        mem[dn_req_addr + i] =
                            dn_req_wdata[8*((dn_req_addr[1:0] + i) % 4) +: 8];
                    end
                end else begin
                    for (int i = 0; i < 4; i++) begin
                        pend_data[8*i +: 8] = rdb({dn_req_addr[31:2], 2'b00} + i);
                    end
                end
            end
            if (prev_stall) begin
                check(dn_req_valid && dn_req_addr == prev_addr, "R11 downstream hold",
                      dn_req_addr, prev_addr);
            end
            prev_stall = dn_req_valid && !dn_req_ready;
            prev_addr = dn_req_addr;
            if (busy && up_req_ready) begin
                check(1'b0, "R10 ready while busy", 32'h1, 32'h0);
            end
            if (up_rsp_valid && exp_q.size() != 0) begin
                check(1'b0, "R8 early response", exp_q.size(), 32'h0);
            end
        end
    end

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            dn_rsp_valid = 1'b0;
            pend_act = 1'b0;
            prev_stall = 1'b0;
        end else begin
            if (hs_rsp) dn_rsp_valid = 1'b0;
            if (hs_req && !hs_req_wr) begin
                pend_act = 1'b1;
                pend_cnt = rnd_mode ? $urandom_range(0, 2) : 0;
            end else if (pend_act) begin
                if (pend_cnt == 0) begin
                    dn_rsp_valid = 1'b1;
                    dn_rsp_rdata = pend_data;
                    pend_act = 1'b0;
                end else begin
                    pend_cnt--;
                end
            end
            dn_req_ready = rnd_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(1'b0, "R8 watchdog expired", cyc, 150000);
            finish_run();
        end
    end

    task automatic do_req(input logic [31:0] addr, input bit wr, input logic [1:0] sz,
                          input logic [31:0] wd, input string tag);
        bit          alias_hit;
        int          nb, idx, stall;
        logic [31:0] t, v, newv, exp_rd, got, first;
        alias_hit = (addr[31:25] == 7'h11) || (addr[31:25] == 7'h21);
        nb = 1 << sz;
        newv = '0;
        t = '0;
        if (alias_hit) begin
            t = ((addr[31:25] == 7'h11) ? 32'h2000_0000 : 32'h4000_0000) |
                ((addr & 32'h01FF_FFFF) >> 5);
            t = t & ~(nb - 1);
            idx = (addr >> 2) & (8 * nb - 1);
            v = '0;
            for (int i = 0; i < nb; i++) v |= 32'(rdb(t + i)) << (8 * i);
            exp_rd = wr ? 32'h0 : ((v >> idx) & 32'h1);
            newv = wd[0] ? (v | (32'h1 << idx)) : (v & ~(32'h1 << idx));
            exp_q.push_back({1'b0, sz, t});
            if (wr) exp_q.push_back({1'b1, sz, t});
        end else begin
            exp_rd = '0;
            if (!wr) for (int i = 0; i < 4; i++) exp_rd[8*i +: 8] = rdb({addr[31:2], 2'b00} + i);
            exp_q.push_back({wr, sz, addr});
        end
        @(posedge clk); #1;
        up_req_valid = 1'b1;
        up_req_addr = addr;
        up_req_write = wr;
        up_req_size = sz;
        up_req_wdata = wd;
        do @(negedge clk); while (!up_req_ready);
        @(posedge clk); #1;
        up_req_valid = 1'b0;
        busy = 1'b1;
        do @(negedge clk); while (!up_rsp_valid);
        first = up_rsp_rdata;
        stall = rnd_mode ? $urandom_range(0, 2) : 0;
        for (int s = 0; s < stall; s++) begin
            @(negedge clk);
            check(up_rsp_valid && up_rsp_rdata == first, "R11 response hold",
                  up_rsp_rdata, first);
        end
        @(posedge clk); #1;
        up_rsp_ready = 1'b1;
        @(negedge clk);
        got = up_rsp_rdata;
        @(posedge clk); #1;
        up_rsp_ready = 1'b0;
        busy = 1'b0;
        check(got == exp_rd, tag, got, exp_rd);
        check(exp_q.size() == 0, "R8 R9 transactions done", exp_q.size(), 0);
        if (alias_hit && wr) begin
            v = '0;
            for (int i = 0; i < nb; i++) v |= 32'(rdb(t + i)) << (8 * i);
            check(v == newv, "R6 read-modify-write result", v, newv);
        end else if (wr) begin
            for (int i = 0; i < nb; i++) begin
                check(rdb(addr + i) == wd[8*((addr[1:0] + i) % 4) +: 8],
                      "R9 forwarded write data", rdb(addr + i),
                      wd[8*((addr[1:0] + i) % 4) +: 8]);
            end
        end
    endtask

    initial begin
        mem[32'h2000_0004] = 8'hA5;
        mem[32'h2000_0006] = 8'h3C;
        mem[32'h2000_0007] = 8'h81;
        mem[32'h4000_1230] = 8'h78;
        mem[32'h4000_1231] = 8'h56;
        mem[32'h4000_1232] = 8'h34;
        mem[32'h4000_1233] = 8'h12;
        mem[32'h21FF_FFFC] = 8'h5A;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(up_req_ready && !up_rsp_valid && !dn_req_valid, "R1 reset idle",
              {29'h0, up_req_ready, up_rsp_valid, dn_req_valid}, 32'h4);

        // byte alias reads of 0xA5 at target 0x20000004
        for (int b = 0; b < 8; b++) begin
            do_req(32'h2200_0080 + 32'(b * 4), 1'b0, 2'd0, '0, "R4 R5 byte alias read");
        end
        // halfword reads, odd target offset forced even
        do_req(32'h2200_00E0 + 32'(2 * 4), 1'b0, 2'd1, '0, "R3 R4 half alias read");
        do_req(32'h2200_00E0 + 32'(8 * 4), 1'b0, 2'd1, '0, "R3 R4 half alias read");
        do_req(32'h2200_00E0 + 32'(15 * 4), 1'b0, 2'd1, '0, "R3 R4 half alias read");
        // word reads in window B, offset 0x1233 forced to 0x1230
        do_req(32'h4202_4660 + 32'(4 * 4), 1'b0, 2'd2, '0, "R2 R3 word alias read");
        do_req(32'h4202_4660 + 32'(3 * 4), 1'b0, 2'd2, '0, "R2 R3 word alias read");
        do_req(32'h4202_4660 + 32'(28 * 4), 1'b0, 2'd2, '0, "R2 R4 word alias read");
        // alias writes
        do_req(32'h2200_0080 + 32'(1 * 4), 1'b1, 2'd0, 32'h1, "R6 byte alias set");
        do_req(32'h2200_0080 + 32'(7 * 4), 1'b1, 2'd0, 32'hFFFF_FFFE, "R6 byte alias clear");
        do_req(32'h2200_00C0 + 32'(9 * 4), 1'b1, 2'd1, 32'h1, "R6 half alias set");
        do_req(32'h4202_4600 + 32'(4 * 4), 1'b1, 2'd2, 32'h0, "R6 word alias clear");
        // forwarded traffic and window edges
        do_req(32'h2000_0010, 1'b1, 2'd2, 32'hDEAD_BEEF, "R9 forwarded write");
        do_req(32'h2000_0011, 1'b0, 2'd0, '0, "R9 forwarded read");
        do_req(32'h2000_0012, 1'b1, 2'd1, 32'hCAFE_0000, "R9 forwarded half write");
        do_req(32'h21FF_FFFC, 1'b0, 2'd2, '0, "R2 below window passes");
        do_req(32'h2400_0000, 1'b0, 2'd2, '0, "R2 above window passes");
        do_req(32'h23FF_FFFC, 1'b0, 2'd2, '0, "R2 R3 last alias word");

        // randomized traffic with back-pressure on both sides
        rnd_mode = 1'b1;
        for (int k = 0; k < 80; k++) begin
            logic [1:0]  sz;
            logic [31:0] a;
            bit          wr;
            sz = 2'($urandom_range(0, 2));
            wr = $urandom_range(0, 1) != 0;
            if ($urandom_range(0, 2) != 0) begin
                a = ($urandom_range(0, 1) != 0 ? 32'h2200_0000 : 32'h4202_4600) |
                    32'($urandom_range(0, 15) << 5) | 32'($urandom_range(0, 7) << 2);
                do_req(a, wr, sz, $urandom, wr ? "R6 random alias write" : "R5 random alias read");
            end else begin
                a = (32'h2000_0000 | 32'($urandom_range(0, 15))) & ~32'((1 << sz) - 1);
                do_req(a, wr, sz, $urandom, "R9 random forwarded");
            end
        end
        finish_run();
    end

endmodule